// File: doc/BRIEF.md
# FIFO Control, Status and Interrupt Register Bank

This block is the software-facing register bank for a pair of data FIFOs: one that carries words out of the system (TX) and one that carries words into it (RX). The FIFO storage and any clock-domain crossing are outside the block. Occupancy counts, full and empty flags, and the RX head word arrive as inputs. The block returns push and pop strobes, FIFO reset levels and an endpoint select. A processor reaches the block over a plain synchronous word bus with separate write and read strobes and a 3-bit word address. Read data is combinational on the address.

Writing the TX data word pushes that word into the TX FIFO in the same cycle. Reading the RX data word returns the head word and pops it in the same cycle. Two comparators derive a programmable-full flag for RX and a programmable-empty flag for TX from a threshold register. Two small state machines record illegal accesses. Each has the states ERR_CLEAR and ERR_LATCHED. ERR_CLEAR goes to ERR_LATCHED on a bad access while that FIFO is not held in reset. ERR_LATCHED returns to ERR_CLEAR while the FIFO reset bit is set.

Four interrupt sources are edge-latched into a pending register. Software clears the pending register by writing ones to it. A single interrupt line reports the enabled pending bits.

Top module: `fifo_regs_ctrl`

## Requirements
- R1: After reset, the control, threshold, enable and pending registers read 0, and irq is low.
- R2: Control register (word 0) bit layout:
  - Bit 0 drives tx_fifo_rst.
  - Bit 1 drives rx_fifo_rst.
  - Bits 5:4 drive ep_sel.
  - Reads return those bits in place; every other bit reads 0.
- R3: Threshold register (word 1):
  - Bits 31:16 hold the RX threshold.
  - Bits 15:0 hold the TX threshold.
  - The whole word reads back as written.
- R4: The RX programmable-full flag is 1 exactly when rx_count is greater than the RX threshold.
- R5: The TX programmable-empty flag is 1 exactly when tx_count is less than the TX threshold.
- R6: Status register (word 2) bit layout:
  - Bits 31:20: tx_count.
  - Bit 19: TX programmable-empty.
  - Bit 18: TX overflow.
  - Bit 17: tx_full.
  - Bit 16: tx_empty.
  - Bits 15:4: rx_count.
  - Bit 3: RX programmable-full.
  - Bit 2: RX underflow.
  - Bit 1: rx_full.
  - Bit 0: rx_empty.
- R7: A write to word 3 raises tx_push in the same cycle, with tx_wdata equal to bus_wdata, unless tx_full is 1. A read of word 3 returns 0.
- R8: A read of word 4 returns rx_head and raises rx_pop in the same cycle, unless rx_empty is 1.
- R9: TX overflow (status bit 18):
  - It becomes 1 in the cycle after a write to word 3 while tx_full is 1.
  - It stays 1 until a cycle in which control bit 0 is 1; it is 0 in the cycle after that.
  - A reset cycle wins over a new overflow in the same cycle.
- R10: RX underflow (status bit 2):
  - It becomes 1 in the cycle after a read of word 4 while rx_empty is 1.
  - It stays 1 until a cycle in which control bit 1 is 1; it is 0 in the cycle after that.
  - A reset cycle wins over a new underflow in the same cycle.
- R11: Pending register (word 6) bit assignment:
  - Bit 0: RX programmable-full.
  - Bit 1: TX programmable-empty.
  - Bit 2: TX overflow.
  - Bit 3: RX underflow.
  - A pending bit sets in the cycle after its source rises.
  - Writing 1 to a pending bit clears it.
  - A rise in the same cycle as a clear leaves the bit set.
- R12: Enable register (word 5) bits 3:0 read back as written. irq is 1 exactly when some pending bit and its enable bit are both 1.
- R13: A read of word 7 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on bus_addr |
| tx_fifo_rst | output | 1 | TX FIFO reset level |
| rx_fifo_rst | output | 1 | RX FIFO reset level |
| ep_sel | output | 2 | Endpoint select |
| tx_push | output | 1 | Push strobe to the TX FIFO |
| tx_wdata | output | 32 | Word pushed into the TX FIFO |
| tx_count | input | TX_CNT_W | TX occupancy in words |
| tx_full | input | 1 | TX FIFO full |
| tx_empty | input | 1 | TX FIFO empty |
| rx_pop | output | 1 | Pop strobe to the RX FIFO |
| rx_head | input | 32 | Word at the head of the RX FIFO |
| rx_count | input | RX_CNT_W | RX occupancy in words |
| rx_full | input | 1 | RX FIFO full |
| rx_empty | input | 1 | RX FIFO empty |
| irq | output | 1 | Interrupt request |

## Verification
The stimulus mixes random bus operations with random occupancy and flag inputs. Counts and thresholds are drawn from a narrow range so that "greater than", "equal" and "less than" all occur often. This separates a correct strict comparison from an off-by-one or inverted one. Directed cases cover the following:
- Counts exactly at the thresholds.
- Writes into a full TX FIFO and reads from an empty RX FIFO, which show the sticky latch and its reset release.
- A pending-clear write in the same cycle as a source rising, which shows the set-over-clear priority.

Frequent writes to the enable and pending registers show whether irq follows only the enabled pending bits.

// File: rtl/fifo_regs_pkg.sv
package fifo_regs_pkg;

    localparam int WORD_W  = 32;
    localparam int ADDR_W  = 3;
    localparam int NUM_SRC = 4;

    // interrupt source positions in the enable and pending registers
    localparam int IRQ_RXPF  = 0;
    localparam int IRQ_TXPE  = 1;
    localparam int IRQ_TXOVF = 2;
    localparam int IRQ_RXUNF = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL    = 3'd0,
        REG_THRESH  = 3'd1,
        REG_STATUS  = 3'd2,
        REG_TXDATA  = 3'd3,
        REG_RXDATA  = 3'd4,
        REG_IRQEN   = 3'd5,
        REG_IRQPEND = 3'd6
    } reg_addr_e;

    typedef enum logic {
        ERR_CLEAR,
        ERR_LATCHED
    } err_state_e;

    typedef struct packed {
        logic [1:0] ep;
        logic       rx_rst;
        logic       tx_rst;
    } ctrl_t;

endpackage

// File: rtl/fifo_err_fsm.sv
module fifo_err_fsm
    import fifo_regs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bad_access,
    input  logic fifo_rst,
    output logic flag
);

    err_state_e state_q;
    err_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ERR_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: the FIFO reset dominates a new bad access
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ERR_CLEAR:   if (bad_access && !fifo_rst) state_d = ERR_LATCHED;
            ERR_LATCHED: if (fifo_rst)                state_d = ERR_CLEAR;
        endcase
    end

    // outputs
    always_comb begin
        flag = (state_q == ERR_LATCHED);
    end

endmodule

// File: rtl/fifo_level_cmp.sv
module fifo_level_cmp #(
    parameter int CNT_W = 12,
    parameter int THR_W = 16,
    parameter bit ABOVE = 1'b1
) (
    input  logic [CNT_W-1:0] count,
    input  logic [THR_W-1:0] thr,
    output logic             hit
);

    localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

    logic [CMP_W-1:0] count_ext;
    logic [CMP_W-1:0] thr_ext;

    assign count_ext = CMP_W'(count);
    assign thr_ext   = CMP_W'(thr);

    generate
        if (ABOVE) begin : g_above
            assign hit = count_ext > thr_ext;
        end else begin : g_below
            assign hit = count_ext < thr_ext;
        end
    endgenerate

endmodule

// File: rtl/fifo_irq_unit.sv
module fifo_irq_unit #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src,
    input  logic         en_wr,
    input  logic         pend_wr,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] en_q,
    output logic [N-1:0] pend_q,
    output logic         irq
);

    logic [N-1:0] src_q;
    logic [N-1:0] rise;
    logic [N-1:0] clr;

    assign rise = src & ~src_q;
    assign clr  = pend_wr ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= '0;
            en_q   <= '0;
            pend_q <= '0;
        end else begin
            src_q  <= src;
            pend_q <= (pend_q & ~clr) | rise;
            if (en_wr) begin
                en_q <= wdata;
            end
        end
    end

    assign irq = |(pend_q & en_q);

endmodule

// File: rtl/fifo_regs_ctrl.sv
module fifo_regs_ctrl
    import fifo_regs_pkg::*;
#(
    parameter int TX_CNT_W = 12,
    parameter int RX_CNT_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    output logic                tx_fifo_rst,
    output logic                rx_fifo_rst,
    output logic [1:0]          ep_sel,
    output logic                tx_push,
    output logic [WORD_W-1:0]   tx_wdata,
    input  logic [TX_CNT_W-1:0] tx_count,
    input  logic                tx_full,
    input  logic                tx_empty,
    output logic                rx_pop,
    input  logic [WORD_W-1:0]   rx_head,
    input  logic [RX_CNT_W-1:0] rx_count,
    input  logic                rx_full,
    input  logic                rx_empty,
    output logic                irq
);

    localparam int THR_W   = WORD_W / 2;
    localparam int CNT_FLD = (WORD_W / 2) - 4;

    reg_addr_e          sel;
    ctrl_t              ctrl_q;
    logic [WORD_W-1:0]  thr_q;
    logic [NUM_SRC-1:0] src;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] pend_q;
    logic               rx_pf;
    logic               tx_pe;
    logic               tx_ovf_flag;
    logic               rx_unf_flag;
    logic               wr_txdata;
    logic               rd_rxdata;
    logic [WORD_W-1:0]  status_w;

    assign sel       = reg_addr_e'(bus_addr);
    assign wr_txdata = bus_wr && (sel == REG_TXDATA);
    assign rd_rxdata = bus_rd && (sel == REG_RXDATA);

    // writable registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            thr_q  <= '0;
        end else if (bus_wr) begin
            if (sel == REG_CTRL) begin
                ctrl_q <= '{ep: bus_wdata[5:4], rx_rst: bus_wdata[1], tx_rst: bus_wdata[0]};
            end
            if (sel == REG_THRESH) begin
                thr_q <= bus_wdata;
            end
        end
    end

    assign tx_fifo_rst = ctrl_q.tx_rst;
    assign rx_fifo_rst = ctrl_q.rx_rst;
    assign ep_sel      = ctrl_q.ep;

    // data ports
    assign tx_push  = wr_txdata && !tx_full;
    assign tx_wdata = bus_wdata;
    assign rx_pop   = rd_rxdata && !rx_empty;

    // programmable level flags
    fifo_level_cmp #(.CNT_W(RX_CNT_W), .THR_W(THR_W), .ABOVE(1'b1)) rx_cmp_i (
        .count (rx_count),
        .thr   (thr_q[WORD_W-1:THR_W]),
        .hit   (rx_pf)
    );

    fifo_level_cmp #(.CNT_W(TX_CNT_W), .THR_W(THR_W), .ABOVE(1'b0)) tx_cmp_i (
        .count (tx_count),
        .thr   (thr_q[THR_W-1:0]),
        .hit   (tx_pe)
    );

    // sticky error trackers
    fifo_err_fsm tx_err_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bad_access (wr_txdata && tx_full),
        .fifo_rst   (ctrl_q.tx_rst),
        .flag       (tx_ovf_flag)
    );

    fifo_err_fsm rx_err_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bad_access (rd_rxdata && rx_empty),
        .fifo_rst   (ctrl_q.rx_rst),
        .flag       (rx_unf_flag)
    );

    // interrupts
    assign src[IRQ_RXPF]  = rx_pf;
    assign src[IRQ_TXPE]  = tx_pe;
    assign src[IRQ_TXOVF] = tx_ovf_flag;
    assign src[IRQ_RXUNF] = rx_unf_flag;

    fifo_irq_unit #(.N(NUM_SRC)) irq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .src     (src),
        .en_wr   (bus_wr && (sel == REG_IRQEN)),
        .pend_wr (bus_wr && (sel == REG_IRQPEND)),
        .wdata   (bus_wdata[NUM_SRC-1:0]),
        .en_q    (en_q),
        .pend_q  (pend_q),
        .irq     (irq)
    );

    // status word
    assign status_w = {CNT_FLD'(tx_count), tx_pe, tx_ovf_flag, tx_full, tx_empty,
                       CNT_FLD'(rx_count), rx_pf, rx_unf_flag, rx_full, rx_empty};

    // read mux
    always_comb begin
        case (sel)
            REG_CTRL:    bus_rdata = {{(WORD_W-6){1'b0}}, ctrl_q.ep, 2'b00, ctrl_q.rx_rst, ctrl_q.tx_rst};
            REG_THRESH:  bus_rdata = thr_q;
            REG_STATUS:  bus_rdata = status_w;
            REG_RXDATA:  bus_rdata = rx_head;
            REG_IRQEN:   bus_rdata = {{(WORD_W-NUM_SRC){1'b0}}, en_q};
            REG_IRQPEND: bus_rdata = {{(WORD_W-NUM_SRC){1'b0}}, pend_q};
            default:     bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/fifo_regs_ctrl_chk.sv
module fifo_regs_ctrl_chk
    import fifo_regs_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               tx_full,
    input logic               rx_empty,
    input logic               tx_fifo_rst,
    input logic               rx_fifo_rst,
    input logic               tx_ovf,
    input logic               rx_unf,
    input logic               rx_pf,
    input logic [NUM_SRC-1:0] pend,
    input logic               irq
);

    assert_ovf_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd3 && tx_full && !tx_fifo_rst) |=> tx_ovf);

    assert_ovf_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ovf && !tx_fifo_rst) |=> tx_ovf);

    assert_ovf_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fifo_rst |=> !tx_ovf);

    assert_unf_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd4 && rx_empty && !rx_fifo_rst) |=> rx_unf);

    assert_pend_on_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_pf) |=> pend[IRQ_RXPF]);

    assert_irq_drop_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(bus_wr && (bus_addr == 3'd5 || bus_addr == 3'd6)));

endmodule

bind fifo_regs_ctrl fifo_regs_ctrl_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .tx_full     (tx_full),
    .rx_empty    (rx_empty),
    .tx_fifo_rst (tx_fifo_rst),
    .rx_fifo_rst (rx_fifo_rst),
    .tx_ovf      (tx_ovf_flag),
    .rx_unf      (rx_unf_flag),
    .rx_pf       (rx_pf),
    .pend        (pend_q),
    .irq         (irq)
);

// File: tb/fifo_regs_ctrl_tb_top.sv
module fifo_regs_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_fifo_rst, rx_fifo_rst, tx_push, rx_pop, irq;
    logic [1:0]  ep_sel;
    logic [31:0] tx_wdata;
    logic [11:0] tx_count = '0, rx_count = '0;
    logic        tx_full = 1'b0, tx_empty = 1'b1, rx_full = 1'b0, rx_empty = 1'b1;
    logic [31:0] rx_head = '0;

    always #10 clk = ~clk;

    fifo_regs_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_fifo_rst(tx_fifo_rst),
        .rx_fifo_rst(rx_fifo_rst), .ep_sel(ep_sel), .tx_push(tx_push), .tx_wdata(tx_wdata),
        .tx_count(tx_count), .tx_full(tx_full), .tx_empty(tx_empty), .rx_pop(rx_pop),
        .rx_head(rx_head), .rx_count(rx_count), .rx_full(rx_full), .rx_empty(rx_empty),
        .irq(irq)
    );

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    // reference model state
    logic [31:0] m_ctrl = '0, m_thr = '0;
    logic [3:0]  m_en = '0, m_pend = '0, m_srcq = '0;
    logic        m_ovf = 1'b0, m_unf = 1'b0;
    logic [31:0] last_rdata;

    // staged FIFO-side inputs, applied inside the cycle task
    logic [11:0] nx_tc = '0, nx_rc = '0;
    logic        nx_tf = 1'b0, nx_te = 1'b1, nx_rf = 1'b0, nx_re = 1'b1;
    logic [31:0] nx_head = '0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic m_rxpf();
        return {4'b0, rx_count} > m_thr[31:16];
    endfunction

    function automatic logic m_txpe();
        return {4'b0, tx_count} < m_thr[15:0];
    endfunction

    function automatic logic [31:0] exp_rdata(input logic [2:0] a);
        case (a)
            3'd0: return m_ctrl & 32'h33;
            3'd1: return m_thr;
            3'd2: return {tx_count, m_txpe(), m_ovf, tx_full, tx_empty,
                          rx_count, m_rxpf(), m_unf, rx_full, rx_empty};
            3'd4: return rx_head;
            3'd5: return {28'b0, m_en};
            3'd6: return {28'b0, m_pend};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string addr_tag(input logic [2:0] a);
        case (a)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R6";
            3'd3: return "R7";
            3'd4: return "R8";
            3'd5: return "R12";
            3'd6: return "R11";
            default: return "R13";
        endcase
    endfunction

    task automatic cycle(input bit wr, input bit rd, input logic [2:0] a, input logic [31:0] wd);
        logic [3:0] src, clr;
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
        tx_count = nx_tc; rx_count = nx_rc; tx_full = nx_tf; tx_empty = nx_te;
        rx_full = nx_rf; rx_empty = nx_re; rx_head = nx_head;
        #1;
        last_rdata = bus_rdata;
        check("R7 push", {31'b0, tx_push}, {31'b0, wr && a == 3'd3 && !tx_full});
        if (tx_push) check("R7 data", tx_wdata, wd);
        check("R8 pop", {31'b0, rx_pop}, {31'b0, rd && a == 3'd4 && !rx_empty});
        check("R2 outputs", {28'b0, ep_sel, rx_fifo_rst, tx_fifo_rst},
              {28'b0, m_ctrl[5:4], m_ctrl[1:0]});
        check("R12 irq", {31'b0, irq}, {31'b0, |(m_pend & m_en)});
        if (rd) check(addr_tag(a), bus_rdata, exp_rdata(a));
        // advance the model to the state after the coming edge
        src = {m_unf, m_ovf, m_txpe(), m_rxpf()};
        clr = (wr && a == 3'd6) ? wd[3:0] : 4'h0;
        m_pend = (m_pend & ~clr) | (src & ~m_srcq);
        m_srcq = src;
        if (m_ctrl[0]) m_ovf = 1'b0; else if (wr && a == 3'd3 && tx_full) m_ovf = 1'b1;
        if (m_ctrl[1]) m_unf = 1'b0; else if (rd && a == 3'd4 && rx_empty) m_unf = 1'b1;
        if (wr && a == 3'd0) m_ctrl = wd & 32'h33;
        if (wr && a == 3'd1) m_thr = wd;
        if (wr && a == 3'd5) m_en = wd[3:0];
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1f2e3d4c));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        cycle(0, 1, 3'd0, 0); check("R1 ctrl", last_rdata, 32'h0);
        cycle(0, 1, 3'd1, 0); check("R1 thresh", last_rdata, 32'h0);
        cycle(0, 1, 3'd5, 0); check("R1 enable", last_rdata, 32'h0);
        cycle(0, 1, 3'd6, 0); check("R1 pending", last_rdata, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R2 control bits and endpoint
        cycle(1, 0, 3'd0, 32'hFFFF_FFDC);
        cycle(0, 1, 3'd0, 0); check("R2 readback", last_rdata, 32'h10);
        check("R2 ep_sel", {30'b0, ep_sel}, 32'h1);
        cycle(1, 0, 3'd0, 32'h0);

        // R3 threshold and R4/R5 boundaries
        cycle(1, 0, 3'd1, {16'd5, 16'd7});
        cycle(0, 1, 3'd1, 0); check("R3 thresh", last_rdata, {16'd5, 16'd7});
        nx_rc = 12'd5; nx_tc = 12'd7; nx_re = 0; nx_te = 0;
        cycle(0, 1, 3'd2, 0);
        check("R4 equal", {31'b0, last_rdata[3]}, 32'h0);
        check("R5 equal", {31'b0, last_rdata[19]}, 32'h0);
        nx_rc = 12'd6; nx_tc = 12'd6;
        cycle(0, 1, 3'd2, 0);
        check("R4 above", {31'b0, last_rdata[3]}, 32'h1);
        check("R5 below", {31'b0, last_rdata[19]}, 32'h1);

        // R9 overflow latch and release
        nx_tf = 1;
        cycle(1, 0, 3'd3, 32'hA5A5_0001);
        nx_tf = 0;
        cycle(0, 1, 3'd2, 0); check("R9 set", {31'b0, last_rdata[18]}, 32'h1);
        cycle(0, 1, 3'd2, 0); check("R9 hold", {31'b0, last_rdata[18]}, 32'h1);
        cycle(1, 0, 3'd0, 32'h1);
        cycle(1, 0, 3'd0, 32'h0);
        cycle(0, 1, 3'd2, 0); check("R9 cleared", {31'b0, last_rdata[18]}, 32'h0);

        // R10 underflow latch and release
        nx_re = 1; nx_rc = 0;
        cycle(0, 1, 3'd4, 0);
        cycle(0, 1, 3'd2, 0); check("R10 set", {31'b0, last_rdata[2]}, 32'h1);
        cycle(1, 0, 3'd0, 32'h2);
        cycle(1, 0, 3'd0, 32'h0);
        cycle(0, 1, 3'd2, 0); check("R10 cleared", {31'b0, last_rdata[2]}, 32'h0);

        // R11 set wins over clear in the same cycle
        cycle(1, 0, 3'd6, 32'hF);
        cycle(1, 0, 3'd1, {16'd0, 16'd0});
        nx_rc = 12'd0;
        cycle(1, 0, 3'd6, 32'hF);
        nx_rc = 12'd1; nx_re = 0;
        cycle(1, 0, 3'd6, 32'h1);
        cycle(0, 1, 3'd6, 0); check("R11 rise over clear", {31'b0, last_rdata[0]}, 32'h1);
        cycle(1, 0, 3'd5, 32'h1);
        cycle(0, 0, 3'd0, 0); check("R12 irq on", {31'b0, irq}, 32'h1);
        cycle(0, 1, 3'd7, 0); check("R13 unused", last_rdata, 32'h0);

        // random traffic
        for (int i = 0; i < 6000; i++) begin
            int op = $urandom_range(0, 9);
            logic [2:0]  a  = 3'($urandom_range(0, 7));
            logic [31:0] wd = $urandom;
            nx_tc = 12'($urandom_range(0, 12));
            nx_rc = 12'($urandom_range(0, 12));
            nx_te = (nx_tc == 0);
            nx_re = (nx_rc == 0) || ($urandom_range(0, 5) == 0);
            nx_tf = ($urandom_range(0, 3) == 0);
            nx_rf = ($urandom_range(0, 3) == 0);
            nx_head = $urandom;
            if (a == 3'd1) wd = {12'b0, 4'($urandom_range(0, 13)), 12'b0, 4'($urandom_range(0, 13))};
            if (a == 3'd0) wd = (wd & 32'hFFFF_FFFC) | (($urandom_range(0, 7) == 0) ? 32'($urandom_range(1, 3)) : 32'h0);
            if (op < 4)      cycle(1, 0, a, wd);
            else if (op < 8) cycle(0, 1, a, 0);
            else             cycle(0, 0, a, 0);
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule